// File: doc/BRIEF.md
# Polled Keyboard Input Port

This block sits on a simple byte-wide CPU bus and holds the most recent key event for software to collect. A key source hands over a character code with a valid/ready handshake. The port captures the code into a keycode register and raises a ready flag in a status register. Software polls the status byte until it becomes nonzero, then reads the keycode byte. It acknowledges the key by writing zero to the status byte.

The port holds a single entry. If a second key arrives before software has acknowledged the first, the new code replaces the old one and a sticky overrun flag records the lost key. Bus reads come straight from the stored values through combinational logic, with no wait cycles. The input stream never sees back-pressure: `key_ready` is held high, so every beat with `key_valid` high is accepted on that clock edge. A source may therefore treat `key_valid` as a one-cycle strobe.

The status register sits at the base address and the keycode register at base + 1. The block answers a window of 16 byte addresses that starts at the base.

Top module: `kbd_port`

## Requirements
- R1: After reset, the status byte and the keycode byte both read as 0x00.
- R2: `key_ready` is always 1. A cycle with `key_valid` high stores `key_code` in the keycode register and sets status bit 0 (ready), visible from the next cycle.
- R3: A read (`bus_sel` high, `bus_we` low) returns data combinationally in the same cycle. At the base address (default 0xF800) it returns status: bit 0 is ready, bit 1 is overrun, bits 7..2 are zero. At base + 1 it returns the keycode. A read made in the same cycle as a key event returns the old values.
- R4: Writing 0x00 to the status address clears both ready and overrun. The keycode is kept.
- R5: A key event while ready is already 1 overwrites the keycode and sets overrun. Overrun stays set until status is cleared.
- R6: When a key event and a status clear-write happen in the same cycle, the key event wins. Status becomes 0x01 (ready set, overrun clear) and the keycode takes the new code.
- R7: Reads at offsets 2 to 15 of the window, reads outside the window, and idle cycles drive `bus_rdata` to 0x00.
- R8: Writes to the keycode address, writes to any other address, and nonzero writes to the status address change neither register.
- R9: Reading status or keycode has no side effect on either register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| key_valid | input | 1 | Key event strobe from the key source |
| key_ready | output | 1 | Always 1; the port never stalls the source |
| key_code | input | 8 | Character code of the key event |
| bus_sel | input | 1 | Bus access strobe for this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 16 | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data |

## Verification
Two functions can land on the same cycle: a key arriving and the software clear-write to status. A read can also coincide with a key arrival. The bench provokes the first case directly by driving `key_valid` together with a zero write to the status address, and the second by reading while a key strobe is in flight. The random phase then produces further collisions, because both strobes fire frequently. A bench model in which the key event has priority judges each result by reading status and keycode back on the following cycles: the coincident clear must leave 0x01 and the new code, and the coincident read must show the values stored before that edge.

// File: rtl/kbd_pkg.sv
package kbd_pkg;
  // register offsets within the decode window; software depends on these
  localparam int unsigned OFS_STATUS = 0;
  localparam int unsigned OFS_CODE   = 1;

  // status bit positions
  localparam int unsigned BIT_READY   = 0;
  localparam int unsigned BIT_OVERRUN = 1;

  typedef struct packed {
    logic ovr;
    logic rdy;
  } kbd_flags_t;

  typedef enum logic [1:0] {
    SEL_NONE   = 2'd0,
    SEL_STATUS = 2'd1,
    SEL_CODE   = 2'd2,
    SEL_HOLE   = 2'd3
  } kbd_target_e;
endpackage

// File: rtl/kbd_addr_decode.sv
module kbd_addr_decode
  import kbd_pkg::*;
#(
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned WIN_BITS = 4,
  parameter logic [ADDR_W-1:0] BASE = 16'hF800
) (
  input  logic [ADDR_W-1:0] addr,
  output kbd_target_e       target
);
  localparam int unsigned TAG_W = ADDR_W - WIN_BITS;

  logic [TAG_W-1:0]    tag;
  logic [WIN_BITS-1:0] ofs;
  logic                in_win;

  assign tag    = addr[ADDR_W-1:WIN_BITS];
  assign ofs    = addr[WIN_BITS-1:0];
  assign in_win = (tag == BASE[ADDR_W-1:WIN_BITS]);

  always_comb begin
    if (!in_win)
      target = SEL_NONE;
    else if (ofs == WIN_BITS'(OFS_STATUS))
      target = SEL_STATUS;
    else if (ofs == WIN_BITS'(OFS_CODE))
      target = SEL_CODE;
    else
      target = SEL_HOLE;
  end
endmodule

// File: rtl/kbd_event_regs.sv
module kbd_event_regs
  import kbd_pkg::*;
#(
  parameter int unsigned CODE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              key_fire,
  input  logic [CODE_W-1:0] key_code,
  input  logic              clr,
  output kbd_flags_t        flags,
  output logic [CODE_W-1:0] code
);
  kbd_flags_t        flags_q;
  logic [CODE_W-1:0] code_q;

  // key event has priority; a coincident clear only drops the earlier state
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags_q <= '0;
      code_q  <= '0;
    end else if (key_fire) begin
      code_q      <= key_code;
      flags_q.rdy <= 1'b1;
      flags_q.ovr <= clr ? 1'b0 : (flags_q.ovr | flags_q.rdy);
    end else if (clr) begin
      flags_q <= '0;
    end
  end

  assign flags = flags_q;
  assign code  = code_q;
endmodule

// File: rtl/kbd_read_mux.sv
module kbd_read_mux
  import kbd_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              rd_en,
  input  kbd_target_e       target,
  input  kbd_flags_t        flags,
  input  logic [DATA_W-1:0] code,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] status_word;

  always_comb begin
    status_word              = '0;
    status_word[BIT_READY]   = flags.rdy;
    status_word[BIT_OVERRUN] = flags.ovr;
  end

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      unique case (target)
        SEL_STATUS: rdata = status_word;
        SEL_CODE:   rdata = code;
        default:    rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/kbd_port.sv
module kbd_port
  import kbd_pkg::*;
#(
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned WIN_BITS = 4,
  parameter logic [ADDR_W-1:0] BASE = 16'hF800
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              key_valid,
  output logic              key_ready,
  input  logic [DATA_W-1:0] key_code,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata
);
  kbd_target_e       target;
  kbd_flags_t        flags;
  logic              st_rdy;
  logic              st_ovr;
  logic [DATA_W-1:0] code_q;
  logic              clr;
  logic              rd_en;
  logic              key_fire;

  assign key_ready = 1'b1;
  assign key_fire  = key_valid & key_ready;
  assign rd_en     = bus_sel & ~bus_we;
  assign clr       = bus_sel & bus_we & (target == SEL_STATUS) & (bus_wdata == '0);

  kbd_addr_decode #(
    .ADDR_W(ADDR_W), .WIN_BITS(WIN_BITS), .BASE(BASE)
  ) u_dec (
    .addr(bus_addr), .target(target)
  );

  kbd_event_regs #(.CODE_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .key_fire(key_fire), .key_code(key_code),
    .clr(clr), .flags(flags), .code(code_q)
  );

  assign st_rdy = flags.rdy;
  assign st_ovr = flags.ovr;

  kbd_read_mux #(.DATA_W(DATA_W)) u_mux (
    .rd_en(rd_en), .target(target), .flags(flags), .code(code_q), .rdata(bus_rdata)
  );
endmodule

// File: rtl/kbd_port_chk.sv
module kbd_port_chk #(
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned WIN_BITS = 4,
  parameter logic [ADDR_W-1:0] BASE = 16'hF800
) (
  input logic              clk,
  input logic              rst_n,
  input logic              key_valid,
  input logic [DATA_W-1:0] key_code,
  input logic              bus_sel,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              st_rdy,
  input logic              st_ovr,
  input logic [DATA_W-1:0] code_q
);
  logic in_win;
  logic [WIN_BITS-1:0] ofs;
  logic wr_zero_status;
  logic rd;

  assign in_win = bus_addr[ADDR_W-1:WIN_BITS] == BASE[ADDR_W-1:WIN_BITS];
  assign ofs    = bus_addr[WIN_BITS-1:0];
  assign rd     = bus_sel && !bus_we;
  assign wr_zero_status = bus_sel && bus_we && in_win && ofs == '0 && bus_wdata == '0;

  assert_key_loads_R2: assert property (@(posedge clk) disable iff (!rst_n)
    key_valid |=> st_rdy && code_q == $past(key_code));

  assert_clear_both_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_zero_status && !key_valid |=> !st_rdy && !st_ovr);

  assert_overrun_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    key_valid && st_rdy && !wr_zero_status |=> st_ovr);

  assert_overrun_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    st_ovr && !wr_zero_status |=> st_ovr);

  assert_key_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    key_valid && wr_zero_status |=> st_rdy && !st_ovr);

  assert_hole_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd && in_win && ofs != '0 && ofs != 1) || bus_rdata == '0);

  assert_code_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !key_valid |=> $stable(code_q));

  assert_code_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd && in_win && ofs == 1) || bus_rdata == code_q);
endmodule

bind kbd_port kbd_port_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WIN_BITS(WIN_BITS), .BASE(BASE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .key_valid(key_valid), .key_code(key_code),
  .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata), .st_rdy(st_rdy), .st_ovr(st_ovr), .code_q(code_q)
);

// File: tb/kbd_port_test.sv
module kbd_port_test;
  localparam logic [15:0] BASE = 16'hF800;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic key_valid = 1'b0;
  logic key_ready;
  logic [7:0] key_code = '0;
  logic bus_sel = 1'b0;
  logic bus_we = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;

  always #5 clk = ~clk;

  kbd_port uut (
    .clk(clk), .rst_n(rst_n), .key_valid(key_valid), .key_ready(key_ready),
    .key_code(key_code), .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  logic m_rdy = 1'b0;
  logic m_ovr = 1'b0;
  logic [7:0] m_code = '0;

  function automatic logic [7:0] exp_read(logic [15:0] a);
    if (a[15:4] != BASE[15:4]) return 8'h00;
    if (a[3:0] == 4'd0) return {6'b0, m_ovr, m_rdy};
    if (a[3:0] == 4'd1) return m_code;
    return 8'h00;
  endfunction

  function automatic string addr_req(logic [15:0] a);
    if (a[15:4] == BASE[15:4] && a[3:0] < 4'd2) return "R3";
    return "R7";
  endfunction

  task automatic chk8(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic cyc(logic kv, logic [7:0] kc, logic sel, logic we,
                     logic [15:0] a, logic [7:0] wd, string req);
    logic clr;
    @(negedge clk);
    key_valid = kv; key_code = kc; bus_sel = sel; bus_we = we;
    bus_addr = a; bus_wdata = wd;
    #1;
    if (sel && !we) chk8(req, bus_rdata, exp_read(a));
    else chk8("R7", bus_rdata, 8'h00);
    @(posedge clk);
    clr = sel && we && a == BASE && wd == 8'h00;
    if (kv) begin
      m_code = kc;
      if (clr) begin m_rdy = 1'b1; m_ovr = 1'b0; end
      else begin m_ovr = m_ovr | m_rdy; m_rdy = 1'b1; end
    end else if (clr) begin
      m_rdy = 1'b0; m_ovr = 1'b0;
    end
  endtask

  task automatic rd(logic [15:0] a, string req);
    cyc(1'b0, 8'h00, 1'b1, 1'b0, a, 8'h00, req);
  endtask

  task automatic wr(logic [15:0] a, logic [7:0] d);
    cyc(1'b0, 8'h00, 1'b1, 1'b1, a, d, "R8");
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1: reset values
    rd(BASE, "R1");
    rd(BASE + 16'd1, "R1");

    // R2: key captured, never stalled
    checks++;
    if (key_ready !== 1'b1) begin errors++; $display("FAIL R2 actual=%b expected=1", key_ready); end
    cyc(1'b1, 8'h41, 1'b0, 1'b0, BASE, 8'h00, "R2");
    rd(BASE, "R2");
    rd(BASE + 16'd1, "R2");

    // R9: reads leave state untouched
    rd(BASE, "R9");
    rd(BASE + 16'd1, "R9");
    rd(BASE, "R9");

    // R5: second key before acknowledge
    cyc(1'b1, 8'h42, 1'b0, 1'b0, BASE, 8'h00, "R5");
    rd(BASE, "R5");
    rd(BASE + 16'd1, "R5");

    // R8: ignored writes
    wr(BASE + 16'd1, 8'h55);
    rd(BASE + 16'd1, "R8");
    wr(BASE, 8'h07);
    rd(BASE, "R8");
    wr(BASE + 16'd5, 8'h00);
    wr(16'h1230, 8'h00);
    rd(BASE, "R8");

    // R4: clear by zero write, keycode kept
    wr(BASE, 8'h00);
    rd(BASE, "R4");
    rd(BASE + 16'd1, "R4");

    // R6: key and clear in the same cycle, with overrun pending
    cyc(1'b1, 8'h61, 1'b0, 1'b0, BASE, 8'h00, "R6");
    cyc(1'b1, 8'h62, 1'b0, 1'b0, BASE, 8'h00, "R6");
    cyc(1'b1, 8'h63, 1'b1, 1'b1, BASE, 8'h00, "R6");
    rd(BASE, "R6");
    rd(BASE + 16'd1, "R6");

    // R7: holes and foreign addresses
    rd(BASE + 16'd2, "R7");
    rd(BASE + 16'd15, "R7");
    rd(16'h1234, "R7");
    rd(BASE + 16'd16, "R7");

    // R3: read coincident with key returns pre-edge values
    cyc(1'b1, 8'h70, 1'b1, 1'b0, BASE + 16'd1, 8'h00, "R3");
    cyc(1'b1, 8'h71, 1'b1, 1'b0, BASE, 8'h00, "R3");
    rd(BASE, "R3");

    // random phase
    for (int i = 0; i < 3000; i++) begin
      logic [15:0] a;
      logic [7:0] d;
      int pick;
      pick = $urandom_range(0, 9);
      if (pick < 4) a = BASE;
      else if (pick < 7) a = BASE + 16'd1;
      else if (pick < 9) a = BASE + 16'($urandom_range(2, 15));
      else a = 16'($urandom);
      d = ($urandom_range(0, 2) == 0) ? 8'($urandom) : 8'h00;
      cyc($urandom_range(0, 3) == 0, 8'($urandom), $urandom_range(0, 1) == 1,
          $urandom_range(0, 2) == 0, a, d, addr_req(a));
    end

    @(negedge clk);
    key_valid = 1'b0; bus_sel = 1'b0;
    done = 1'b1;
    summary();
    $finish;
  end
endmodule